// File: doc/BRIEF.md
# Prioritized Interrupt Pending and Daisy-Chain Controller

This block is the interrupt core of a two-channel serial peripheral. Each channel has three interrupt sources (receive, transmit and external/status), six in all. For each source the block holds a pending bit, which is set and cleared by event pulses from the datapath, and an under-service bit, which marks a source whose acknowledge has been taken. From these bits it drives an active-low request line, an enable output for lower-priority devices on a daisy chain, and a vector that can carry the code of the winning source.

An acknowledge cycle is tracked by a small state machine with three states. `ACK_IDLE` means no acknowledge is in progress. `ACK_ARMED` means the acknowledge strobe is high and the read strobe is not yet high. `ACK_HELD` means the read strobe has been seen and the under-service bit has been taken. The transitions are:
- IDLE to ARMED when `intack` rises without `rd_stb`.
- IDLE to HELD when both strobes are high together.
- ARMED to HELD when `rd_stb` goes high.
- ARMED to IDLE, or HELD to IDLE, when `intack` drops.

Entry into HELD is the single cycle in which an under-service bit may be set. A nested service ends when software issues the reset-highest command. That command retires only the highest-priority source still under service, so the lower-priority services underneath it resume in order.

Top module: `sio_irq_chain`

## Requirements
- R1: `int_n` is low only when `mie`, `iei` and `src_en[i]` are all high and the pending bit of some source i is set with no under-service bit set at index i or lower (higher priority).
- R2: `int_n` is high whenever `intack` is high.
- R3: On the cycle `rd_stb` is first seen high while `intack` is high, the under-service bit of the highest-priority eligible source is set. Exactly one such bit is set, and no under-service bit is set at any other time.
- R4: A pending bit stays set until its clear pulse arrives, so in polled use `int_n` stays low until the source is cleared.
- R5: `set_ev[i]` sets pending bit i and `clr_ev[i]` clears it on the next clock edge. When both arrive in the same cycle, the set wins.
- R6: A source of higher priority than every source under service can raise a new request (nesting). A source at or below the priority of any source under service cannot.
- R7: A `rst_hius` pulse clears only the highest-priority under-service bit that is set.
- R8: `ieo` is high only when `iei` is high and no pending or under-service bit is set.
- R9: `vec_raw` always equals `vec_base`. When `vis` is high, `vec_stat` equals `vec_base` with bits [3:1] replaced by the code of the winning eligible source (index+1, or 0 when none). When `vis` is low, `vec_stat` equals `vec_base`.
- R10: The source indices are 0 channel A receive, 1 channel A transmit, 2 channel A external/status, 3 channel B receive, 4 channel B transmit and 5 channel B external/status. A lower index has higher priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| set_ev | input | 6 | per-source pending set pulse |
| clr_ev | input | 6 | per-source pending clear pulse (data write, data read, status reset command) |
| mie | input | 1 | master interrupt enable |
| src_en | input | 6 | per-source interrupt enable |
| iei | input | 1 | daisy-chain enable in |
| intack | input | 1 | acknowledge cycle in progress |
| rd_stb | input | 1 | read strobe, active high |
| rst_hius | input | 1 | reset-highest-under-service command pulse |
| vis | input | 1 | vector includes status |
| vec_base | input | 8 | shared vector register value |
| int_n | output | 1 | active-low interrupt request |
| ieo | output | 1 | daisy-chain enable out |
| vec_raw | output | 8 | unmodified vector |
| vec_stat | output | 8 | vector with source code when enabled |

## Verification
The bench goes after nesting. A new higher-priority source must raise the request over a lower source under service, while a still-lower source stays blocked. A design that compared against pending bits instead of under-service bits would either lose the nested request or let the blocked source through. It checks that the reset-highest command retires one bit only: a design clearing all under-service bits would unblock the lower source too early, and that shows as a premature request. It also covers the read-strobe timing of the acknowledge, where a design that set the bit on the acknowledge strobe alone would change the vector code before the read, and the same-cycle set and clear of a pending bit, where a clear-wins design would silently drop an event.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,
        ACK_ARMED = 2'd1,
        ACK_HELD  = 2'd2
    } ack_state_e;
endpackage

// File: rtl/sio_irq_pick.sv
// Fixed-priority picker: lowest index wins, result as a one-hot mask.
module sio_irq_pick #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [N-1:0] onehot
);
    always_comb begin
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                onehot    = '0;
                onehot[i] = 1'b1;
            end
        end
        any = |req;
    end
endmodule

// File: rtl/sio_irq_ack_fsm.sv
// Tracks one acknowledge cycle; take pulses on entry into ACK_HELD.
module sio_irq_ack_fsm
    import sio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic intack,
    input  logic rd_stb,
    output logic take
);
    ack_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ACK_IDLE: begin
                if (intack && rd_stb) begin
                    state_d = ACK_HELD;
                    take    = 1'b1;
                end else if (intack) begin
                    state_d = ACK_ARMED;
                end
            end
            ACK_ARMED: begin
                if (!intack) begin
                    state_d = ACK_IDLE;
                end else if (rd_stb) begin
                    state_d = ACK_HELD;
                    take    = 1'b1;
                end
            end
            ACK_HELD: begin
                if (!intack) state_d = ACK_IDLE;
            end
            default: state_d = ACK_IDLE;
        endcase
    end

    AST_FSM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_q inside {ACK_IDLE, ACK_ARMED, ACK_HELD}); // R3
endmodule

// File: rtl/sio_irq_bank.sv
// Pending and under-service bit storage.
module sio_irq_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr_ev,
    input  logic [N-1:0] ius_set,
    input  logic [N-1:0] ius_clr,
    output logic [N-1:0] ip_q,
    output logic [N-1:0] ius_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q  <= '0;
            ius_q <= '0;
        end else begin
            ip_q  <= (ip_q & ~clr_ev) | set_ev;
            ius_q <= (ius_q & ~ius_clr) | ius_set;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        |set_ev |=> ((ip_q & $past(set_ev)) == $past(set_ev))); // R5
endmodule

// File: rtl/sio_irq_chain.sv
module sio_irq_chain #(
    parameter int NSRC     = 6,
    parameter int VEC_W    = 8,
    parameter int CODE_LSB = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  set_ev,
    input  logic [NSRC-1:0]  clr_ev,
    input  logic             mie,
    input  logic [NSRC-1:0]  src_en,
    input  logic             iei,
    input  logic             intack,
    input  logic             rd_stb,
    input  logic             rst_hius,
    input  logic             vis,
    input  logic [VEC_W-1:0] vec_base,
    output logic             int_n,
    output logic             ieo,
    output logic [VEC_W-1:0] vec_raw,
    output logic [VEC_W-1:0] vec_stat
);
    localparam int CW = $clog2(NSRC + 1);

    logic [NSRC-1:0] ip_q, ius_q, blocked, elig, elig_oh, hius_oh;
    logic [NSRC-1:0] ius_set, ius_clr;
    logic            elig_any, hius_any, take;
    logic [CW-1:0]   code;

    // blocked[i]: some source at index <= i is under service
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            acc        = acc | ius_q[i];
            blocked[i] = acc;
        end
    end

    assign elig = ip_q & src_en & ~blocked & {NSRC{mie & iei}};

    sio_irq_pick #(.N(NSRC)) u_pick_req (
        .req(elig), .any(elig_any), .onehot(elig_oh));

    sio_irq_pick #(.N(NSRC)) u_pick_hius (
        .req(ius_q), .any(hius_any), .onehot(hius_oh));

    sio_irq_ack_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .intack(intack), .rd_stb(rd_stb), .take(take));

    assign ius_set = take ? elig_oh : '0;
    assign ius_clr = (rst_hius && hius_any) ? hius_oh : '0;

    sio_irq_bank #(.N(NSRC)) u_bank (
        .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_ev(clr_ev),
        .ius_set(ius_set), .ius_clr(ius_clr), .ip_q(ip_q), .ius_q(ius_q));

    always_comb begin
        code = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig_oh[i]) code = CW'(i + 1);
        end
    end

    always_comb begin
        vec_stat = vec_base;
        if (vis) vec_stat[CODE_LSB +: CW] = code;
    end

    assign vec_raw = vec_base;
    assign int_n   = !(elig_any && !intack);
    assign ieo     = iei && !(|ip_q) && !(|ius_q);

    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> (mie && iei)); // R1
    AST_NO_REQ_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        intack |-> int_n); // R2
    AST_IUS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ius_q & ~$past(ius_q))) |-> $past(intack && rd_stb)); // R3
    AST_ONE_IUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ius_q & ~$past(ius_q)) <= 1); // R3
    AST_ONE_IUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $countones($past(ius_q) & ~ius_q) <= 1); // R7
    AST_IEO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ip_q) || (|ius_q) || !iei) |-> !ieo); // R8
    AST_RAW_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        vec_raw == vec_base); // R9
endmodule

// File: tb/sio_irq_chain_bench.sv
`timescale 1ns/1ps
module sio_irq_chain_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] set_ev = '0, clr_ev = '0, src_en = '0;
    logic       mie = 1'b0, iei = 1'b1, intack = 1'b0, rd_stb = 1'b0;
    logic       rst_hius = 1'b0, vis = 1'b0;
    logic [7:0] vec_base = 8'hA0;
    logic       int_n, ieo;
    logic [7:0] vec_raw, vec_stat;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    sio_irq_chain u_sio_irq_chain (
        .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_ev(clr_ev), .mie(mie),
        .src_en(src_en), .iei(iei), .intack(intack), .rd_stb(rd_stb),
        .rst_hius(rst_hius), .vis(vis), .vec_base(vec_base),
        .int_n(int_n), .ieo(ieo), .vec_raw(vec_raw), .vec_stat(vec_stat));

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_set(input int i);
        set_ev[i] = 1'b1; step(); set_ev = '0;
    endtask

    task automatic pulse_clr(input int i);
        clr_ev[i] = 1'b1; step(); clr_ev = '0;
    endtask

    task automatic do_ack(input logic [2:0] exp_code);
        intack = 1'b1; step();
        chk("R2 int_n during ack", int_n, 1'b1);
        chk("R9 code before read", vec_stat[3:1], exp_code);
        rd_stb = 1'b1; step();
        rd_stb = 1'b0; intack = 1'b0; step();
    endtask

    task automatic t_reset();
        chk("R8 reset ieo", ieo, 1'b1);
        chk("R1 reset int_n", int_n, 1'b1);
        chk("R9 raw vector", vec_raw, 8'hA0);
    endtask

    task automatic t_gating();
        pulse_set(0);
        chk("R1 mie low blocks", int_n, 1'b1);
        chk("R8 ip blocks ieo", ieo, 1'b0);
        mie = 1'b1; src_en = 6'h3F; #1;
        chk("R1 request raised", int_n, 1'b0);
        src_en[0] = 1'b0; #1;
        chk("R1 source enable low", int_n, 1'b1);
        src_en[0] = 1'b1; iei = 1'b0; #1;
        chk("R1 iei low blocks", int_n, 1'b1);
        iei = 1'b1; #1;
    endtask

    task automatic t_polled();
        step(); step();
        chk("R4 request held", int_n, 1'b0);
        pulse_clr(0);
        chk("R4 cleared", int_n, 1'b1);
        chk("R8 ieo free", ieo, 1'b1);
    endtask

    task automatic t_set_wins();
        set_ev[2] = 1'b1; clr_ev[2] = 1'b1; step();
        set_ev = '0; clr_ev = '0;
        chk("R5 set wins", int_n, 1'b0);
        pulse_clr(2);
        chk("R5 clear", int_n, 1'b1);
    endtask

    task automatic t_nesting();
        vis = 1'b1;
        pulse_set(4);
        chk("R10 code of B tx", vec_stat, 8'hAA);
        do_ack(3'd5);
        chk("R3 served no request", int_n, 1'b1);
        chk("R8 ius blocks ieo", ieo, 1'b0);
        pulse_set(5);
        chk("R6 lower blocked", int_n, 1'b1);
        pulse_set(1);
        chk("R6 higher nests", int_n, 1'b0);
        chk("R10 code of A tx", vec_stat[3:1], 3'd2);
        do_ack(3'd2);
        pulse_clr(1);
        rst_hius = 1'b1; step(); rst_hius = 1'b0;
        chk("R7 only highest cleared", int_n, 1'b1);
        pulse_clr(4);
        rst_hius = 1'b1; step(); rst_hius = 1'b0;
        chk("R7 second clear", int_n, 1'b0);
        chk("R9 status vector", vec_stat, 8'hAC);
        vis = 1'b0; #1;
        chk("R9 vis off", vec_stat, 8'hA0);
        pulse_clr(5);
        chk("R8 idle ieo", ieo, 1'b1);
    endtask

    task automatic t_read_edge();
        pulse_set(3);
        intack = 1'b1; step(); step();
        intack = 1'b0; step();
        chk("R3 no ius without read", int_n, 1'b0);
        pulse_clr(3);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1; step();
        t_reset();
        t_gating();
        t_polled();
        t_set_wins();
        t_read_edge();
        t_nesting();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule